// File: doc/BRIEF.md
# Edge-Triggered Interrupt Line Controller

This block watches a bank of event lines that are already synchronous to its clock and turns their transitions into latched interrupt requests. For each line, software picks whether a rising edge, a falling edge or both should count. Rising and falling detections land in two separate pending registers. Software clears a pending bit by writing a one to it. A software-trigger register raises the same pending state as a hardware edge would.

A per-line interrupt output stays high while either pending bit of that line is set and the line's mask bit allows it. All registers are reached through a single-cycle port: a write enable, a 3-bit word address, write data and combinational read data. Lines marked as absent in the `VALID` parameter behave as holes in every register. With the default parameters, line 19 of lines 0 to 20 is such a hole.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0 and every `irq` bit is 0. The previous-sample register of the edge detector also resets to 0, so a line that is high as reset ends counts as a rising edge.
- R2: An edge is detected by comparing `evt_in` with its value at the previous clock edge. The transition 0→1 on a line whose rise-select bit (address 0) is set sets that line's rising pending bit (address 3) at that clock edge. The transition 1→0 with fall-select (address 1) set does the same for the falling pending bit (address 4). A level held steady sets nothing more.
- R3: A line with both select bits set records rising edges and falling edges separately. A line with neither select bit set records nothing.
- R4: Writing to address 3 or 4 clears each pending bit where the write data holds a 1. Bits written with 0 keep their value, and pending bits change by no other write.
- R5: When a clear write and a new qualifying edge reach the same line in the same clock, the pending bit ends up set.
- R6: A write to address 0 in the clock where a rising edge is seen prevents every rising pending bit from being set by hardware in that clock. A write to address 1 does the same for falling pending bits. The select values in force before the write decide which edges qualify.
- R7: Writing a 1 to address 2 sets, in that clock, the rising pending bit of that line if rise-select is set and the falling pending bit if fall-select is set. A line with neither select bit set is unaffected. Address 2 always reads 0.
- R8: `irq[i]` equals (rising pending[i] OR falling pending[i]) AND mask[i]. The mask is at address 5 and resets to 0.
- R9: Bit positions that are 0 in `VALID` read 0 in every register, ignore writes and never become pending.
- R10: Addresses 6 and 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_in | input | NLINES | Synchronous event lines |
| bus_we | input | 1 | Write strobe, one write per clock |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | NLINES | Write data |
| bus_rdata | output | NLINES | Read data for `bus_addr`, combinational |
| irq | output | NLINES | Per-line masked interrupt request |

## Verification
The hardest case to reach is a line transition that falls in exactly the clock in which a register write is in flight. This covers both the suppression caused by a select-register write and the priority of a new edge over a clear. The bench reaches it by changing `evt_in` and starting the write in the same stimulus step, so both are seen at one clock edge. It then lets a long stretch of random writes and line toggles hit the same window repeatedly, with a reference model tracking the expected state on every clock.

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
  parameter int NLINES = 21,
  parameter logic [NLINES-1:0] VALID = 21'h17FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] evt_in,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [NLINES-1:0] bus_wdata,
  output logic [NLINES-1:0] bus_rdata,
  output logic [NLINES-1:0] irq
);
  localparam logic [2:0] A_RSEL  = 3'd0;
  localparam logic [2:0] A_FSEL  = 3'd1;
  localparam logic [2:0] A_SWT   = 3'd2;
  localparam logic [2:0] A_RPEND = 3'd3;
  localparam logic [2:0] A_FPEND = 3'd4;
  localparam logic [2:0] A_MASK  = 3'd5;

  logic [NLINES-1:0] in_q, rise_en, fall_en, rise_pend, fall_pend, mask_q;
  logic [NLINES-1:0] wd, sw, rise_set, fall_set, rise_clr, fall_clr;

  assign wd = bus_wdata & VALID;
  assign sw = (bus_we && bus_addr == A_SWT) ? wd : '0;

  assign rise_set = ((bus_we && bus_addr == A_RSEL) ? '0 : (evt_in & ~in_q & rise_en))
                  | (sw & rise_en);
  assign fall_set = ((bus_we && bus_addr == A_FSEL) ? '0 : (~evt_in & in_q & fall_en))
                  | (sw & fall_en);
  assign rise_clr = (bus_we && bus_addr == A_RPEND) ? wd : '0;
  assign fall_clr = (bus_we && bus_addr == A_FPEND) ? wd : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q      <= '0;
      rise_en   <= '0;
      fall_en   <= '0;
      mask_q    <= '0;
      rise_pend <= '0;
      fall_pend <= '0;
    end else begin
      in_q      <= evt_in;
      rise_pend <= ((rise_pend & ~rise_clr) | rise_set) & VALID;
      fall_pend <= ((fall_pend & ~fall_clr) | fall_set) & VALID;
      if (bus_we) begin
        case (bus_addr)
          A_RSEL:  rise_en <= wd;
          A_FSEL:  fall_en <= wd;
          A_MASK:  mask_q  <= wd;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_RSEL:  bus_rdata = rise_en;
      A_FSEL:  bus_rdata = fall_en;
      A_RPEND: bus_rdata = rise_pend;
      A_FPEND: bus_rdata = fall_pend;
      A_MASK:  bus_rdata = mask_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq = (rise_pend | fall_pend) & mask_q;
endmodule

// File: rtl/edge_irq_ctrl_chk.sv
module edge_irq_ctrl_chk #(
  parameter int NLINES = 21,
  parameter logic [NLINES-1:0] VALID = 21'h17FFFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NLINES-1:0] evt_in,
  input logic              bus_we,
  input logic [2:0]        bus_addr,
  input logic [NLINES-1:0] bus_rdata,
  input logic [NLINES-1:0] irq,
  input logic [NLINES-1:0] in_q,
  input logic [NLINES-1:0] rise_en,
  input logic [NLINES-1:0] fall_en,
  input logic [NLINES-1:0] rise_pend,
  input logic [NLINES-1:0] fall_pend
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (rise_pend == '0 && fall_pend == '0 && irq == '0));

  assert_level_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(bus_we) && $past(evt_in == in_q)) |->
      ((rise_pend & ~$past(rise_pend)) == '0 && (fall_pend & ~$past(fall_pend)) == '0));

  assert_rise_clear_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(bus_we && bus_addr == 3'd3)) |-> ((~rise_pend & $past(rise_pend)) == '0));

  assert_fall_clear_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(bus_we && bus_addr == 3'd4)) |-> ((~fall_pend & $past(fall_pend)) == '0));

  assert_rsel_collision_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(bus_we && bus_addr == 3'd0)) |-> ((rise_pend & ~$past(rise_pend)) == '0));

  assert_fsel_collision_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(bus_we && bus_addr == 3'd1)) |-> ((fall_pend & ~$past(fall_pend)) == '0));

  assert_swtrig_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd2) |-> (bus_rdata == '0));

  assert_irq_needs_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~(rise_pend | fall_pend)) == '0));

  assert_holes_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (((rise_pend | fall_pend | rise_en | fall_en | bus_rdata) & ~VALID) == '0));

  assert_spare_addr_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[2:1] == 2'b11) |-> (bus_rdata == '0));
endmodule

bind edge_irq_ctrl edge_irq_ctrl_chk #(.NLINES(NLINES), .VALID(VALID)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .irq(irq), .in_q(in_q), .rise_en(rise_en), .fall_en(fall_en),
  .rise_pend(rise_pend), .fall_pend(fall_pend)
);

// File: tb/test_edge_irq_ctrl.sv
module test_edge_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 21;
  localparam logic [N-1:0] V = 21'h17FFFF;

  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [N-1:0] evt_in = '0, bus_wdata = '0;
  logic [2:0] bus_addr = '0;
  logic [N-1:0] bus_rdata, irq;

  edge_irq_ctrl #(.NLINES(N), .VALID(V)) i_edge_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [N-1:0] m_prev = '0, m_ren = '0, m_fen = '0, m_rp = '0, m_fp = '0, m_mask = '0;
  int checks = 0, fails = 0, cycles = 0;
  string cur_req = "R1";
  bit done = 0;

  always @(posedge clk) begin
    logic [N-1:0] re, fe, sw, d;
    if (!rst_n) begin
      m_prev = '0; m_ren = '0; m_fen = '0; m_rp = '0; m_fp = '0; m_mask = '0;
    end else begin
      d = bus_wdata & V;
      re = '0; fe = '0; sw = '0;
      for (int i = 0; i < N; i++) begin
        if (V[i] && m_ren[i] && !m_prev[i] && evt_in[i]) re[i] = 1;
        if (V[i] && m_fen[i] && m_prev[i] && !evt_in[i]) fe[i] = 1;
      end
      if (bus_we && bus_addr == 0) re = '0;
      if (bus_we && bus_addr == 1) fe = '0;
      if (bus_we && bus_addr == 2) sw = d;
      if (bus_we && bus_addr == 3) m_rp = m_rp & ~d;
      if (bus_we && bus_addr == 4) m_fp = m_fp & ~d;
      m_rp = (m_rp | re | (sw & m_ren)) & V;
      m_fp = (m_fp | fe | (sw & m_fen)) & V;
      if (bus_we && bus_addr == 0) m_ren = d;
      if (bus_we && bus_addr == 1) m_fen = d;
      if (bus_we && bus_addr == 5) m_mask = d;
      m_prev = evt_in;
    end
  end

  function automatic logic [N-1:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_ren;
      3'd1: return m_fen;
      3'd3: return m_rp;
      3'd4: return m_fp;
      3'd5: return m_mask;
      default: return '0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      logic [N-1:0] er, ei;
      er = m_read(bus_addr);
      ei = (m_rp | m_fp) & m_mask;
      checks += 2;
      if (bus_rdata !== er) begin
        fails++;
        $display("FAIL %s rdata addr %0d: got %h expected %h", cur_req, bus_addr, bus_rdata, er);
      end
      if (irq !== ei) begin
        fails++;
        $display("FAIL %s irq: got %h expected %h", cur_req, irq, ei);
      end
    end
  end

  task automatic drive(input logic we, input logic [2:0] a, input logic [N-1:0] d,
                       input logic [N-1:0] ev);
    @(negedge clk); #1;
    bus_we = we; bus_addr = a; bus_wdata = d; evt_in = ev;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(0, 3'(k % 8), '0, evt_in);
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    drive(1, a, d, evt_in);
  endtask

  initial begin
    cur_req = "R1";
    evt_in = 21'h000001;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    idle(8);
    cur_req = "R8"; wr(5, '1); idle(4);
    cur_req = "R2"; wr(0, 21'h0000FF); wr(1, 21'h00FF00); idle(2);
    drive(0, 3, '0, 21'h000F0F); idle(8);
    drive(0, 4, '0, 21'h000000); idle(8);
    cur_req = "R4"; wr(3, 21'h000005); idle(2); wr(3, 21'h000000); idle(2);
    wr(3, '1); wr(4, '1); idle(4);
    cur_req = "R3"; wr(0, 21'h1F0000); wr(1, 21'h1F0000);
    drive(0, 3, '0, 21'h1F0000); idle(4); drive(0, 4, '0, 21'h000000); idle(8);
    cur_req = "R5"; drive(1, 3, 21'h1F0000, 21'h1F0000); idle(8);
    drive(1, 4, 21'h1F0000, 21'h000000); idle(8);
    cur_req = "R6"; drive(1, 0, 21'h1F0000, 21'h1F0000); idle(8);
    drive(1, 1, 21'h1F0000, 21'h000000); idle(8);
    drive(1, 0, 21'h0F0000, 21'h1F0000); idle(8);
    cur_req = "R7"; wr(3, '1); wr(4, '1); wr(0, 21'h000003); wr(1, 21'h000006);
    wr(2, 21'h00000F); idle(8);
    cur_req = "R9"; wr(0, '1); wr(1, '1); wr(5, '1); drive(0, 0, '0, '1); idle(8);
    drive(0, 0, '0, '0); idle(8);
    cur_req = "R10"; wr(6, '1); wr(7, '1); idle(8);
    cur_req = "R8"; wr(5, 21'h0A0A0A); idle(8); wr(5, '0); idle(4);
    cur_req = "R5";
    for (int k = 0; k < 3000; k++)
      drive($urandom_range(0, 3) == 0, 3'($urandom_range(0, 7)), N'($urandom),
            evt_in ^ (N'($urandom) & N'($urandom)));
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule